// File: doc/BRIEF.md
# Pulse-Coded ADC Conversion Controller

This block is the host side of a small serial ADC whose one convert-start line does three jobs. It powers the converter up. It holds the track-and-hold in acquisition. It chooses what is converted, through the number of high pulses that come before acquisition. One pulse picks the primary channel, or unipolar mode on differential parts. A short high, a short low and then a second high pick the secondary channel, or bipolar mode. The converter samples on the falling edge of convert-start. It then converts and powers itself down.

A request carries a one-bit selector. The controller plays out the matching pattern on convert-start and keeps the line high for the acquisition time. It then waits out the conversion time and runs exactly twelve serial clocks: ten result bits, MSB first, followed by two sub-bits that it discards. The converter treats a readout that stops early as a request for the secondary selection on the next conversion, so the controller never stops early. The result comes with a flag that marks it as two's complement (bipolar) or straight binary (unipolar). Every time interval is a parameter in system-clock cycles, rounded up from the converter's minimum.

Top module: `adcpc_ctrl`

## Requirements
- R1: During and after reset, `cnv_o`, `sclk_o`, `busy` and `res_valid` are all 0, and `cnv_o` and `sclk_o` stay 0 whenever `busy` is 0.
- R2: A request accepted with `req_sel` = 0 drives `cnv_o` high once, for exactly `ACQ_CYC` cycles, and then low.
- R3: A request accepted with `req_sel` = 1 drives `cnv_o` high for `PULSE_CYC` cycles, low for `PULSE_CYC` cycles, and then high for `ACQ_CYC` cycles.
- R4: `sclk_o` is low while `cnv_o` is high. The first rising edge of `sclk_o` comes exactly `CONV_CYC + HALF_CYC` cycles after `cnv_o` falls, and never sooner than `CONV_CYC` cycles after it.
- R5: Every conversion is followed by exactly `NBITS` (12) serial clock periods, each `HALF_CYC` cycles low and then `HALF_CYC` cycles high. `sdata_i` is shifted in MSB first on the rising edge of `sclk_o` when `CAP_RISE` = 1, and on the falling edge when `CAP_RISE` = 0.
- R6: `res_data` holds the first `RBITS` (10) bits captured, with the first bit in bit 9. The last two captured bits are dropped.
- R7: `res_twos` is 1 (two's complement, bipolar) when the request had `req_sel` = 1, and 0 (straight binary, unipolar) when `req_sel` = 0. `res_data` is passed through as captured.
- R8: `busy` rises in the cycle after a request is accepted and stays high through the single cycle in which `res_valid` is 1. Both are low in the cycle that follows.
- R9: A request made while `busy` is 1 has no effect. It adds no pulse on `cnv_o`, produces no extra result, and does not change the selection or format of the conversion in progress.
- R10: `res_valid` rises `ACQ_CYC + CONV_CYC + 2*NBITS*HALF_CYC` cycles after the accepting edge when `req_sel` = 0. When `req_sel` = 1 it rises `2*PULSE_CYC` cycles later than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request; taken when `busy` is 0 |
| req_sel | input | 1 | 0 = primary channel or unipolar, 1 = secondary channel or bipolar |
| busy | output | 1 | A conversion or readout is in progress |
| cnv_o | output | 1 | Convert-start line to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idle low |
| sdata_i | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle pulse: `res_data` and `res_twos` are valid |
| res_data | output | RBITS | Conversion result |
| res_twos | output | 1 | 1 = result is two's complement, 0 = straight binary |

## Verification
Most sequencer faults appear on `cnv_o` within one conversion. A wrong state, a wrong timer reload or a wrong branch makes a pulse wrong in width or count, and the converter model in the bench sees this at the sampling edge, a few cycles after the request. A wrong bit count or capture edge shows up later, at the end of the same conversion, as a shifted or truncated `res_data`, a wrong number of serial clocks or a changed latency. A fault in the busy gating shows up as an extra pulse or an extra result the next time a request arrives during a readout.

// File: rtl/adcpc_pkg.sv
package adcpc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_GAP,
    ST_ACQ,
    ST_CONV,
    ST_SLO,
    ST_SHI,
    ST_DONE
  } adcpc_state_e;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/adcpc_timer.sv
module adcpc_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/adcpc_capture.sv
module adcpc_capture #(
  parameter int unsigned NBITS    = 12,
  parameter int unsigned RBITS    = 10,
  parameter bit          CAP_RISE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             rise_stb,
  input  logic             fall_stb,
  input  logic             sdata_i,
  output logic [RBITS-1:0] result
);

  logic [NBITS-1:0] word_q;
  logic             shift_en;

  assign shift_en = CAP_RISE ? rise_stb : fall_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (clr) begin
      word_q <= '0;
    end else if (shift_en) begin
      word_q <= {word_q[NBITS-2:0], sdata_i};
    end
  end

  assign result = word_q[NBITS-1 -: RBITS];

endmodule

// File: rtl/adcpc_seq.sv
module adcpc_seq
  import adcpc_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned ACQ_CYC   = 140,
  parameter int unsigned CONV_CYC  = 370,
  parameter int unsigned HALF_CYC  = 5,
  parameter int unsigned NBITS     = 12,
  parameter int unsigned TW        = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_sel,
  input  logic          tmr_exp,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          rise_stb,
  output logic          fall_stb,
  output logic          clr,
  output logic          cnv_q,
  output logic          sclk_q,
  output logic          busy_q,
  output logic          valid_q,
  output logic          sel_q
);

  localparam int unsigned BW = $clog2(NBITS + 1);
  localparam logic [TW-1:0] V_PULSE = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] V_ACQ   = TW'(ACQ_CYC - 1);
  localparam logic [TW-1:0] V_CONV  = TW'(CONV_CYC - 1);
  localparam logic [TW-1:0] V_HALF  = TW'(HALF_CYC - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(NBITS - 1);

  adcpc_state_e state_q, nxt;
  logic [BW-1:0] bit_q;

  always_comb begin
    nxt      = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    rise_stb = 1'b0;
    fall_stb = 1'b0;
    clr      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          clr      = 1'b1;
          tmr_load = 1'b1;
          if (req_sel) begin
            nxt     = ST_PRE;
            tmr_val = V_PULSE;
          end else begin
            nxt     = ST_ACQ;
            tmr_val = V_ACQ;
          end
        end
      end
      ST_PRE: begin
        if (tmr_exp) begin
          nxt      = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = V_PULSE;
        end
      end
      ST_GAP: begin
        if (tmr_exp) begin
          nxt      = ST_ACQ;
          tmr_load = 1'b1;
          tmr_val  = V_ACQ;
        end
      end
      ST_ACQ: begin
        if (tmr_exp) begin
          nxt      = ST_CONV;
          tmr_load = 1'b1;
          tmr_val  = V_CONV;
        end
      end
      ST_CONV: begin
        if (tmr_exp) begin
          nxt      = ST_SLO;
          tmr_load = 1'b1;
          tmr_val  = V_HALF;
        end
      end
      ST_SLO: begin
        if (tmr_exp) begin
          nxt      = ST_SHI;
          tmr_load = 1'b1;
          tmr_val  = V_HALF;
          rise_stb = 1'b1;
        end
      end
      ST_SHI: begin
        if (tmr_exp) begin
          fall_stb = 1'b1;
          if (bit_q == LAST_BIT) begin
            nxt = ST_DONE;
          end else begin
            nxt      = ST_SLO;
            tmr_load = 1'b1;
            tmr_val  = V_HALF;
          end
        end
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      cnv_q   <= 1'b0;
      sclk_q  <= 1'b0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      cnv_q   <= (nxt == ST_PRE) || (nxt == ST_ACQ);
      sclk_q  <= (nxt == ST_SHI);
      busy_q  <= (nxt != ST_IDLE);
      valid_q <= (nxt == ST_DONE);
      if (clr) begin
        sel_q <= req_sel;
        bit_q <= '0;
      end else if (fall_stb) begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adcpc_ctrl.sv
module adcpc_ctrl
  import adcpc_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned ACQ_CYC   = 140,
  parameter int unsigned CONV_CYC  = 370,
  parameter int unsigned HALF_CYC  = 5,
  parameter int unsigned NBITS     = 12,
  parameter int unsigned RBITS     = 10,
  parameter bit          CAP_RISE  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_sel,
  output logic             busy,
  output logic             cnv_o,
  output logic             sclk_o,
  input  logic             sdata_i,
  output logic             res_valid,
  output logic [RBITS-1:0] res_data,
  output logic             res_twos
);

  localparam int unsigned TMAX = max_of4(PULSE_CYC, ACQ_CYC, CONV_CYC, HALF_CYC);
  localparam int unsigned TW   = $clog2(TMAX + 1);

  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          rise_stb, fall_stb, clr;

  adcpc_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  adcpc_seq #(
    .PULSE_CYC (PULSE_CYC),
    .ACQ_CYC   (ACQ_CYC),
    .CONV_CYC  (CONV_CYC),
    .HALF_CYC  (HALF_CYC),
    .NBITS     (NBITS),
    .TW        (TW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_sel   (req_sel),
    .tmr_exp   (tmr_exp),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .clr       (clr),
    .cnv_q     (cnv_o),
    .sclk_q    (sclk_o),
    .busy_q    (busy),
    .valid_q   (res_valid),
    .sel_q     (res_twos)
  );

  adcpc_capture #(
    .NBITS    (NBITS),
    .RBITS    (RBITS),
    .CAP_RISE (CAP_RISE)
  ) u_cap (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .sdata_i  (sdata_i),
    .result   (res_data)
  );

endmodule

// File: rtl/adcpc_ctrl_chk.sv
module adcpc_ctrl_chk #(
  parameter int unsigned NBITS    = 12,
  parameter int unsigned CONV_CYC = 370
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic busy,
  input logic cnv_o,
  input logic sclk_o,
  input logic res_valid
);

  int unsigned wait_cnt;
  int unsigned rise_cnt;
  logic        sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt  <= 0;
      rise_cnt  <= 0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_prev <= sclk_o;
      if (cnv_o) begin
        wait_cnt <= 0;
      end else if (wait_cnt < CONV_CYC) begin
        wait_cnt <= wait_cnt + 1;
      end
      if (cnv_o) begin
        rise_cnt <= 0;
      end else if (sclk_o && !sclk_prev) begin
        rise_cnt <= rise_cnt + 1;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!cnv_o && !sclk_o)); // R1

  AST_NO_SCLK_IN_ACQ: assert property (@(posedge clk) disable iff (rst)
    cnv_o |-> !sclk_o); // R4

  AST_CONV_WAIT: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> (wait_cnt >= CONV_CYC)); // R4

  AST_FULL_READOUT: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (rise_cnt == NBITS)); // R5

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R8

  AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> busy); // R8

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy); // R8

endmodule

bind adcpc_ctrl adcpc_ctrl_chk #(
  .NBITS    (NBITS),
  .CONV_CYC (CONV_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .cnv_o     (cnv_o),
  .sclk_o    (sclk_o),
  .res_valid (res_valid)
);

// File: tb/adcpc_ctrl_bench.sv
module adcpc_ctrl_bench;

  localparam int P  = 2;
  localparam int A  = 6;
  localparam int C  = 8;
  localparam int H  = 2;
  localparam int NB = 12;
  localparam int RB = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_sel = 1'b0;
  logic sdata = 1'b0;
  logic busy, cnv_o, sclk_o, res_valid, res_twos;
  logic [RB-1:0] res_data;

  always #5 clk = ~clk;

  adcpc_ctrl #(
    .PULSE_CYC (P),
    .ACQ_CYC   (A),
    .CONV_CYC  (C),
    .HALF_CYC  (H),
    .NBITS     (NB),
    .RBITS     (RB),
    .CAP_RISE  (1'b1)
  ) u_adcpc_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_sel   (req_sel),
    .busy      (busy),
    .cnv_o     (cnv_o),
    .sclk_o    (sclk_o),
    .sdata_i   (sdata),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_twos  (res_twos)
  );

  int checks = 0;
  int errors = 0;
  int ntx = 0;
  int nres = 0;
  int nconv = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int exp_latency(input bit sel);
    return (sel ? 2 * P : 0) + A + C + 2 * NB * H;
  endfunction

  // converter model
  bit          exp_sel = 1'b0;
  logic [11:0] word_next = '0;
  logic [11:0] sr = '0;
  logic        cnv_prev = 1'b0;
  logic        sclk_prev = 1'b0;
  int hi_len = 0, lo_len = 0, rises = 0, p1_len = 0, gap_len = 0;
  int since_fall = 0, sclk_rises = 0, shi_len = 0;

  always @(negedge clk) begin
    if (rst) begin
      cnv_prev  = 1'b0;
      sclk_prev = 1'b0;
      rises     = 0;
    end else begin
      since_fall++;
      if (cnv_o) begin
        if (!cnv_prev) begin
          rises++;
          hi_len = 1;
          if (rises == 2) gap_len = lo_len;
        end else begin
          hi_len++;
        end
      end else begin
        if (cnv_prev) begin
          lo_len = 1;
          if (hi_len == A) begin
            if (exp_sel) begin
              check(rises == 2, "R3 pulse count", rises, 2);
              check(p1_len == P, "R3 first pulse width", p1_len, P);
              check(gap_len == P, "R3 gap width", gap_len, P);
            end else begin
              check(rises == 1, "R2 pulse count", rises, 1);
            end
            sr         = word_next;
            sdata      = sr[11];
            since_fall = 0;
            sclk_rises = 0;
            rises      = 0;
            nconv++;
          end else if (rises == 1 && exp_sel) begin
            p1_len = hi_len;
          end else begin
            check(1'b0, "R2 acquisition width", hi_len, A);
            rises = 0;
          end
        end else begin
          lo_len++;
        end
      end
      if (sclk_o && !sclk_prev) begin
        sclk_rises++;
        shi_len = 1;
        if (sclk_rises == 1) check(since_fall == C + H, "R4 first serial clock delay", since_fall, C + H);
      end else if (sclk_o) begin
        shi_len++;
      end
      if (!sclk_o && sclk_prev) begin
        check(shi_len == H, "R5 serial clock high time", shi_len, H);
        sr    = {sr[10:0], 1'b0};
        sdata = sr[11];
      end
      cnv_prev  = cnv_o;
      sclk_prev = sclk_o;
    end
  end

  always @(negedge clk) if (!rst && res_valid) nres++;

  task automatic run(input bit sel, input logic [9:0] code, input logic [1:0] sub, input int inject);
    int lat;
    exp_sel   = sel;
    word_next = {code, sub};
    @(negedge clk);
    req_valid = 1'b1;
    req_sel   = sel;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!res_valid && lat < 5000) begin
      if (lat == inject) begin
        req_valid = 1'b1;
        req_sel   = ~sel;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    ntx++;
    check(lat == exp_latency(sel) + 1, "R10 latency", lat, exp_latency(sel) + 1);
    check(res_data == code, "R6 result data", int'(res_data), int'(code));
    check(res_twos == sel, "R7 format flag", int'(res_twos), int'(sel));
    check(busy == 1'b1, "R8 busy during valid", int'(busy), 1);
    check(sclk_rises == NB, "R5 serial clock count", sclk_rises, NB);
    @(negedge clk);
    check(res_valid == 1'b0, "R8 valid lasts one cycle", int'(res_valid), 0);
    check(busy == 1'b0, "R8 busy released", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'd48611));
    repeat (3) @(negedge clk);
    check(cnv_o == 1'b0 && sclk_o == 1'b0, "R1 pins idle in reset", int'({cnv_o, sclk_o}), 0);
    check(busy == 1'b0 && res_valid == 1'b0, "R1 flags idle in reset", int'({busy, res_valid}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(cnv_o == 1'b0 && busy == 1'b0, "R1 idle after reset", int'({cnv_o, busy}), 0);

    // directed corners
    run(1'b0, 10'h000, 2'b11, 0);
    run(1'b1, 10'h3FF, 2'b00, 0);
    run(1'b0, 10'h2AA, 2'b01, 0);
    run(1'b1, 10'h155, 2'b10, 0);
    run(1'b0, 10'h201, 2'b11, 5);   // R9 request during acquisition
    run(1'b1, 10'h1FE, 2'b01, 3);   // R9 request during the gap
    run(1'b1, 10'h0F0, 2'b11, 40);  // R9 request during readout

    for (int i = 0; i < 40; i++) begin
      bit          s;
      logic [9:0]  cd;
      logic [1:0]  sb;
      int          inj;
      s   = 1'($urandom_range(1, 0));
      cd  = 10'($urandom_range(1023, 0));
      sb  = 2'($urandom_range(3, 0));
      inj = ($urandom_range(3, 0) == 0) ? int'($urandom_range(exp_latency(s) - 1, 1)) : 0;
      run(s, cd, sb, inj);
    end

    repeat (30) @(negedge clk);
    check(nres == ntx, "R9 no extra results", nres, ntx);
    check(nconv == ntx, "R9 no extra conversions", nconv, ntx);
    check(cnv_o == 1'b0 && busy == 1'b0, "R9 quiet after last result", int'({cnv_o, busy}), 0);

    // reset in the middle of acquisition
    @(negedge clk);
    req_valid = 1'b1;
    req_sel   = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(cnv_o == 1'b0 && busy == 1'b0 && sclk_o == 1'b0, "R1 reset aborts conversion",
          int'({cnv_o, busy, sclk_o}), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule